// File: doc/BRIEF.md
# Dual-Mode Frequency and Pulse-Width Meter

This block measures one digital input in one of two modes chosen by a configuration bit. In frequency mode it counts rising edges of the conditioned input over a window of programmable length, measured in reference clock cycles. In pulse-width mode it counts reference clock cycles from a selectable start edge to a selectable stop edge. With the right pair of edges it measures the high time, the low time or one full period. An optional gate freezes both the count and the window timer. The gate comes either from a software bit or from an external pin, and its active level is programmable.

A single four-state machine serves both modes. The states and their codes on `state_o` are Idle (0), Armed (1), Measure (2) and Done (3). The transitions are: enable-rise (Idle to Armed); go (Armed to Measure); finish (Measure to Done); and drop (any state to Idle while enable is low). The go transition happens on a start command in frequency mode and on the start edge in pulse-width mode. The finish transition happens when the window timer is empty in frequency mode and on the stop edge in pulse-width mode. Done keeps the result until enable is cleared. The input, the external start and the external gate each pass through a two-flop synchronizer before any edge or level is used.

Top module: `freq_width_meter`

## Requirements
- R1: After reset, `state_o` is 0 (Idle), `result_o` is 0 and `irq_o` is 0. Whenever `cfg_enable` is sampled 0, the next state is Idle. A sampled 0-to-1 change of `cfg_enable` moves Idle to Armed (1) and clears `result_o` to 0.
- R2: In frequency mode (`cfg_mode`=0), Armed moves to Measure (2) in the cycle after the start command. With `cfg_start_ext`=0 the start command is `sw_start` sampled high. With `cfg_start_ext`=1 it is a rising edge of the synchronized `ext_start`, and `sw_start` is ignored.
- R3: On go, the window timer loads `cfg_win_len` = N. Done (3) is entered exactly N+1 cycles after the edge at which go occurred, plus one cycle for every Measure cycle in which the gate was active.
- R4: In frequency mode, `result_o` in Done equals the number of rising edges of the conditioned input (`ext_in` XOR `cfg_invert`) seen in ungated Measure cycles while the timer was non-zero.
- R5: `cfg_invert`=1 inverts the input before edge detection, so falling edges of `ext_in` are counted or matched in place of rising edges.
- R6: In pulse-width mode (`cfg_mode`=1), an edge type bit of 0 selects the rising edge and 1 selects the falling edge (`cfg_start_fall`, `cfg_stop_fall`, both applied to the conditioned input). The result is the number of ungated reference cycles from the start edge up to, but not including, the stop edge. This gives the high time for rising/falling, the low time for falling/rising, and the full period when both edges are the same.
- R7: With `cfg_gate_use`=1, the gate is active when the selected source equals `cfg_gate_level`. The source is `ext_gate` after synchronization if `cfg_gate_ext`=1, and `cfg_gate_sw` otherwise. While the gate is active, no counting takes place and the timer is held. With `cfg_gate_use`=0 the gate signals have no effect.
- R8: In Done, `result_o` and the state stay fixed regardless of the input and start signals until `cfg_enable` is cleared. Re-arming needs `cfg_enable` to go to 0 and then back to 1.
- R9: `result_o` saturates at all ones and does not wrap.
- R10: If `cfg_irq_en`=1, `irq_o` is high for exactly one cycle, the first cycle in Done. If `cfg_irq_en`=0, `irq_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Enable; a rising change arms the meter |
| cfg_mode | input | 1 | 0 frequency, 1 pulse width |
| cfg_start_fall | input | 1 | Start edge type: 0 rising, 1 falling |
| cfg_stop_fall | input | 1 | Stop edge type: 0 rising, 1 falling |
| cfg_invert | input | 1 | Invert the measured input |
| cfg_start_ext | input | 1 | Frequency start source: 0 software, 1 external |
| sw_start | input | 1 | Software start command |
| cfg_gate_use | input | 1 | Gate feature on |
| cfg_gate_ext | input | 1 | Gate source: 0 software bit, 1 external pin |
| cfg_gate_level | input | 1 | Gate active level |
| cfg_gate_sw | input | 1 | Software gate bit |
| cfg_win_len | input | WIN_W | Window length in reference cycles |
| cfg_irq_en | input | 1 | Completion interrupt enable |
| ext_in | input | 1 | Measured signal, asynchronous |
| ext_start | input | 1 | External start, asynchronous |
| ext_gate | input | 1 | External gate, asynchronous |
| state_o | output | 2 | Current state code |
| result_o | output | CNT_W | Measurement result |
| irq_o | output | 1 | One-cycle completion pulse |

## Verification
The bench sweeps high and low times from 1 to 6 cycles over all four edge-pair choices, both with and without inversion. A design that counted the stop-edge cycle, or that missed the start-edge cycle, would report every width and period off by one. The window length is swept from 0 upward, with and without gated cycles. A timer that was off by one, or that kept running while gated, would reach Done one cycle early or late. Other tests target a start from the unselected source being ignored, and the result staying frozen in Done while the input keeps toggling. They also cover a long high time clamping to all ones, where a wrapping counter would return a small value, and an interrupt that would repeat or go missing.

// File: rtl/fwm_pkg.sv
package fwm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARMED   = 2'd1,
        ST_MEASURE = 2'd2,
        ST_DONE    = 2'd3
    } meter_state_e;
endpackage

// File: rtl/fwm_sync.sv
module fwm_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d[b]};
        end
        assign q[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/fwm_front.sv
module fwm_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_in,
    input  logic ext_start,
    input  logic ext_gate,
    input  logic cfg_invert,
    input  logic cfg_start_ext,
    input  logic sw_start,
    input  logic cfg_start_fall,
    input  logic cfg_stop_fall,
    input  logic cfg_gate_use,
    input  logic cfg_gate_ext,
    input  logic cfg_gate_level,
    input  logic cfg_gate_sw,
    output logic start_cmd,
    output logic start_edge,
    output logic stop_edge,
    output logic in_rise,
    output logic gate_hold
);
    localparam int NSIG = 3;
    logic [NSIG-1:0] raw, syn;
    logic sig_now, sig_prev, xst_prev, in_fall, gate_src;

    assign raw = {ext_gate, ext_start, ext_in};

    fwm_sync #(.WIDTH(NSIG), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
    );

    assign sig_now = syn[0] ^ cfg_invert;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sig_prev <= 1'b0;
            xst_prev <= 1'b0;
        end else begin
            sig_prev <= sig_now;
            xst_prev <= syn[1];
        end
    end

    assign in_rise    = sig_now & ~sig_prev;
    assign in_fall    = ~sig_now & sig_prev;
    assign start_edge = cfg_start_fall ? in_fall : in_rise;
    assign stop_edge  = cfg_stop_fall  ? in_fall : in_rise;
    assign start_cmd  = cfg_start_ext ? (syn[1] & ~xst_prev) : sw_start;
    assign gate_src   = cfg_gate_ext ? syn[2] : cfg_gate_sw;
    assign gate_hold  = cfg_gate_use & (gate_src == cfg_gate_level);
endmodule

// File: rtl/fwm_core.sv
module fwm_core
    import fwm_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int WIN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_enable,
    input  logic             cfg_mode,
    input  logic [WIN_W-1:0] cfg_win_len,
    input  logic             cfg_irq_en,
    input  logic             start_cmd,
    input  logic             start_edge,
    input  logic             stop_edge,
    input  logic             in_rise,
    input  logic             gate_hold,
    output meter_state_e     state_o,
    output logic [CNT_W-1:0] result_o,
    output logic             irq_o
);
    meter_state_e     st_q, st_nxt;
    logic             en_q, en_rise, go, finish;
    logic [WIN_W-1:0] win_q;
    logic [CNT_W-1:0] res_q, res_inc;

    assign en_rise = cfg_enable & ~en_q;
    assign go      = cfg_mode ? start_edge : start_cmd;
    assign finish  = cfg_mode ? stop_edge : (win_q == '0);
    assign res_inc = (&res_q) ? res_q : res_q + CNT_W'(1);

    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_IDLE:    if (en_rise) st_nxt = ST_ARMED;
            ST_ARMED:   if (go)      st_nxt = ST_MEASURE;
            ST_MEASURE: if (finish)  st_nxt = ST_DONE;
            ST_DONE:    st_nxt = ST_DONE;
        endcase
        if (!cfg_enable) st_nxt = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            irq_o <= 1'b0;
            win_q <= '0;
            res_q <= '0;
        end else begin
            en_q  <= cfg_enable;
            irq_o <= cfg_irq_en && (st_q == ST_MEASURE) && (st_nxt == ST_DONE);
            if (st_q == ST_IDLE && st_nxt == ST_ARMED) begin
                res_q <= '0;
            end else if (st_q == ST_ARMED && st_nxt == ST_MEASURE) begin
                win_q <= cfg_win_len;
                res_q <= (cfg_mode && !gate_hold) ? CNT_W'(1) : '0;
            end else if (st_q == ST_MEASURE && st_nxt == ST_MEASURE && !gate_hold) begin
                if (cfg_mode) begin
                    res_q <= res_inc;
                end else begin
                    if (in_rise) res_q <= res_inc;
                    win_q <= win_q - WIN_W'(1);
                end
            end
        end
    end

    assign state_o  = st_q;
    assign result_o = res_q;
endmodule

// File: rtl/freq_width_meter.sv
module freq_width_meter #(
    parameter int CNT_W       = 16,
    parameter int WIN_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_enable,
    input  logic             cfg_mode,
    input  logic             cfg_start_fall,
    input  logic             cfg_stop_fall,
    input  logic             cfg_invert,
    input  logic             cfg_start_ext,
    input  logic             sw_start,
    input  logic             cfg_gate_use,
    input  logic             cfg_gate_ext,
    input  logic             cfg_gate_level,
    input  logic             cfg_gate_sw,
    input  logic [WIN_W-1:0] cfg_win_len,
    input  logic             cfg_irq_en,
    input  logic             ext_in,
    input  logic             ext_start,
    input  logic             ext_gate,
    output logic [1:0]       state_o,
    output logic [CNT_W-1:0] result_o,
    output logic             irq_o
);
    logic start_cmd, start_edge, stop_edge, in_rise, gate_hold;
    fwm_pkg::meter_state_e st;

    fwm_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk(clk), .rst_n(rst_n),
        .ext_in(ext_in), .ext_start(ext_start), .ext_gate(ext_gate),
        .cfg_invert(cfg_invert), .cfg_start_ext(cfg_start_ext), .sw_start(sw_start),
        .cfg_start_fall(cfg_start_fall), .cfg_stop_fall(cfg_stop_fall),
        .cfg_gate_use(cfg_gate_use), .cfg_gate_ext(cfg_gate_ext),
        .cfg_gate_level(cfg_gate_level), .cfg_gate_sw(cfg_gate_sw),
        .start_cmd(start_cmd), .start_edge(start_edge), .stop_edge(stop_edge),
        .in_rise(in_rise), .gate_hold(gate_hold)
    );

    fwm_core #(.CNT_W(CNT_W), .WIN_W(WIN_W)) u_core (
        .clk(clk), .rst_n(rst_n),
        .cfg_enable(cfg_enable), .cfg_mode(cfg_mode),
        .cfg_win_len(cfg_win_len), .cfg_irq_en(cfg_irq_en),
        .start_cmd(start_cmd), .start_edge(start_edge), .stop_edge(stop_edge),
        .in_rise(in_rise), .gate_hold(gate_hold),
        .state_o(st), .result_o(result_o), .irq_o(irq_o)
    );

    assign state_o = st;
endmodule

// File: rtl/fwm_chk.sv
module fwm_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_enable,
    input logic [1:0]       state_o,
    input logic [CNT_W-1:0] result_o,
    input logic             irq_o
);
    // R1
    en_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> state_o == 2'd0);

    // R1
    arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_enable) |=> (state_o == 2'd1 && result_o == '0));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd3 && cfg_enable) |=> (state_o == 2'd3 && $stable(result_o)));

    // R9
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == 2'd2 |=> result_o >= $past(result_o));

    // R10
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (state_o == 2'd3 && $past(state_o) != 2'd3));

    // R2
    armed_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == 2'd1 |=> state_o != 2'd3);
endmodule

bind freq_width_meter fwm_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable),
    .state_o(state_o), .result_o(result_o), .irq_o(irq_o)
);

// File: tb/tb_freq_width_meter.sv
module tb_freq_width_meter;
    localparam int CW = 12;
    localparam int WW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_enable = 0, cfg_mode = 0, cfg_start_fall = 0, cfg_stop_fall = 0;
    logic cfg_invert = 0, cfg_start_ext = 0, sw_start = 0, cfg_gate_use = 0;
    logic cfg_gate_ext = 0, cfg_gate_level = 0, cfg_gate_sw = 0, cfg_irq_en = 0;
    logic [WW-1:0] cfg_win_len = '0;
    logic ext_in = 0, ext_start = 0, ext_gate = 0;
    logic [1:0] state_o;
    logic [CW-1:0] result_o;
    logic irq_o;

    int checks = 0;
    int errors = 0;
    int irq_cnt = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    freq_width_meter #(.CNT_W(CW), .WIN_W(WW)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_mode(cfg_mode),
        .cfg_start_fall(cfg_start_fall), .cfg_stop_fall(cfg_stop_fall),
        .cfg_invert(cfg_invert), .cfg_start_ext(cfg_start_ext), .sw_start(sw_start),
        .cfg_gate_use(cfg_gate_use), .cfg_gate_ext(cfg_gate_ext),
        .cfg_gate_level(cfg_gate_level), .cfg_gate_sw(cfg_gate_sw),
        .cfg_win_len(cfg_win_len), .cfg_irq_en(cfg_irq_en),
        .ext_in(ext_in), .ext_start(ext_start), .ext_gate(ext_gate),
        .state_o(state_o), .result_o(result_o), .irq_o(irq_o)
    );

    always @(negedge clk) if (irq_o) irq_cnt++;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic arm();
        cfg_enable = 0;
        step(2);
        cfg_enable = 1;
        step(1);
    endtask

    task automatic wait_done(input int maxc, output int k);
        k = 0;
        while (state_o != 2'd3 && k < maxc) begin
            step(1);
            k++;
        end
    endtask

    task automatic width_case(input bit sf, input bit pf, input bit inv, input int h, input int l);
        int exp, c0;
        bit rs, rp;
        cfg_mode = 1; cfg_start_fall = sf; cfg_stop_fall = pf; cfg_invert = inv;
        cfg_irq_en = 1; ext_in = 0;
        step(4);
        arm();
        c0 = irq_cnt;
        for (int p = 0; p < 3; p++) begin
            ext_in = 1; step(h);
            ext_in = 0; step(l);
        end
        step(6);
        rs = sf ^ inv;
        rp = pf ^ inv;
        exp = (rs == rp) ? h + l : (rs ? l : h);
        chk("R6 state", state_o, 3);
        chk(inv ? "R5 width" : "R6 width", result_o, exp);
        chk("R10 one pulse", irq_cnt - c0, 1);
    endtask

    task automatic freq_count(input int k, input bit inv);
        int kk, exp, held;
        cfg_mode = 0; cfg_start_ext = 0; cfg_invert = inv; cfg_win_len = 80;
        cfg_irq_en = 0; ext_in = 0;
        step(4);
        arm();
        sw_start = 1; step(1); sw_start = 0;
        step(3);
        for (int i = 0; i < k; i++) begin
            ext_in = 1; step(2);
            if (i != k - 1) begin ext_in = 0; step(2); end
        end
        wait_done(200, kk);
        exp = inv ? ((k > 0) ? k - 1 : 0) : k;
        chk(inv ? "R5 count" : "R4 count", result_o, exp);
        held = result_o;
        for (int i = 0; i < 4; i++) begin
            ext_in = ~ext_in; sw_start = ~sw_start; step(2);
        end
        sw_start = 0; ext_in = 0; step(4);
        chk("R8 result held", result_o, held);
        chk("R8 state held", state_o, 3);
    endtask

    task automatic freq_window(input int n, input int g);
        int kk, k;
        cfg_mode = 0; cfg_start_ext = 0; cfg_invert = 0; cfg_win_len = WW'(n);
        ext_in = 0;
        step(4);
        arm();
        sw_start = 1; step(1); sw_start = 0;
        chk("R2 sw start", state_o, 2);
        k = 0;
        if (g > 0) begin
            cfg_gate_use = 1; cfg_gate_ext = 0; cfg_gate_level = 1; cfg_gate_sw = 1;
            step(g);
            cfg_gate_sw = 0;
            k = g;
        end
        wait_done(300, kk);
        chk(g > 0 ? "R7 timer hold" : "R3 window", k + kk, n + 1 + g);
        cfg_gate_use = 0;
    endtask

    initial begin
        int kk;
        step(3);
        chk("R1 reset state", state_o, 0);
        chk("R1 reset result", result_o, 0);
        chk("R1 reset irq", irq_o, 0);
        rst_n = 1;
        step(2);

        // R6 / R5 / R10: width sweep over edge pairs and inversion
        for (int inv = 0; inv < 2; inv++)
            for (int e = 0; e < 4; e++)
                for (int h = 1; h <= 6; h++)
                    for (int l = 1; l <= 6; l++)
                        width_case(e[1], e[0], inv[0], h, l);

        // R3 / R7: window length sweep, with and without gating
        for (int n = 0; n <= 12; n++) freq_window(n, 0);
        for (int n = 1; n <= 8; n++) begin
            freq_window(n, 1);
            freq_window(n, 3);
        end

        // R4 / R5 / R8: edge counts in window
        for (int k = 0; k <= 8; k++) begin
            freq_count(k, 0);
            freq_count(k, 1);
        end

        // R2: external start selected, software start ignored
        cfg_mode = 0; cfg_start_ext = 1; cfg_win_len = 3; ext_in = 0;
        step(4);
        arm();
        sw_start = 1; step(1); sw_start = 0; step(4);
        chk("R2 sw ignored", state_o, 1);
        ext_start = 1; step(2); ext_start = 0; step(4);
        chk("R2 ext start", state_o, 2);
        wait_done(50, kk);
        chk("R2 ext done", state_o, 3);
        cfg_start_ext = 0;

        // R1: enable drop mid-measure, re-arm clears result
        arm();
        sw_start = 1; step(1); sw_start = 0;
        cfg_win_len = 40;
        step(2);
        cfg_enable = 0; step(1);
        chk("R1 drop", state_o, 0);
        cfg_enable = 1; step(1);
        chk("R1 rearm state", state_o, 1);
        chk("R1 rearm clear", result_o, 0);

        // R7: external active-low gate during high time
        cfg_mode = 1; cfg_start_fall = 0; cfg_stop_fall = 1; cfg_invert = 0;
        cfg_gate_use = 1; cfg_gate_ext = 1; cfg_gate_level = 0; ext_gate = 1; ext_in = 0;
        step(4);
        arm();
        ext_in = 1; step(5);
        ext_gate = 0; step(7);
        ext_gate = 1; step(8);
        ext_in = 0; step(6);
        chk("R7 gated width", result_o, 13);

        // R7: gate feature off, gate signals ignored
        cfg_gate_use = 0; ext_gate = 0; cfg_gate_sw = 0;
        step(4);
        arm();
        ext_in = 1; step(10); ext_in = 0; step(6);
        chk("R7 gate unused", result_o, 10);

        // R10: no pulse when disabled
        begin
            int c0;
            cfg_irq_en = 0;
            arm();
            c0 = irq_cnt;
            ext_in = 1; step(4); ext_in = 0; step(6);
            chk("R10 masked", irq_cnt - c0, 0);
            chk("R10 masked done", state_o, 3);
        end

        // R9: long high time saturates
        arm();
        ext_in = 1; step(5000); ext_in = 0; step(6);
        chk("R9 saturate", result_o, (1 << CW) - 1);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule